// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of up to 32 general-purpose lines. Software reaches it over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Every line has its own configuration bits. A line can be a plain input or a plain output. It can also be an interrupt input that detects a level, a single edge of either polarity, or both edges.

Pins pass through a two-stage synchroniser before any logic looks at them. Each interrupt line keeps a status bit. Software acknowledges a status bit by writing a 1 to it, and the status bits are gated by a per-line enable mask. The mask has two write addresses: one clears enables, the other sets them. A single interrupt output is the OR of all enabled, pending lines.

Register offsets: 0x00 line mode (1 = interrupt input), 0x04 direction (1 = output), 0x08 output data, 0x0C synchronised input data, 0x10 interrupt status, 0x14 acknowledge, 0x18 enable mask, 0x1C enable-set, 0x20 polarity (1 = active-low / falling), 0x24 trigger kind (1 = edge, 0 = level), 0x4C dual-edge select.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset every line is a general-purpose input, output data is 0, all mask enables are 0, all status bits are 0, pin_oe is 0 and irq_o is low.
- R2: pin_oe bit k is high only when mode bit k (0x00) is 0 and direction bit k (0x04) is 1. pin_out is the output data register (0x08), and reading 0x08 returns that driven value.
- R3: Reading 0x0C returns the pin values sampled through two flops, so a pin change is visible two clock edges later.
- R4: An interrupt line (mode 1) in edge mode (0x24 bit 1) with dual-edge bit 0 latches its status bit on a rising edge when its polarity bit (0x20) is 0, and on a falling edge when it is 1. The bit becomes readable at 0x10 three clock edges after the pin changes and stays set until acknowledged.
- R5: With its dual-edge bit (0x4C) set, an edge-mode interrupt line latches on both transitions, whatever its polarity bit.
- R6: In level mode (0x24 bit 0) the status bit follows the pin level XOR polarity bit. Acknowledging it has no effect while the level stays active.
- R7: Writing 0x14 clears the status bits of edge-mode lines whose data bits are 1. Bits written as 0 leave status unchanged.
- R8: If an edge is detected in the same cycle as an acknowledge of that line, the status bit stays set.
- R9: A write to 0x18 clears the enables whose data bits are 0 and leaves the enables written with 1 unchanged. A write to 0x1C sets the enables whose data bits are 1. Reading 0x18 returns the enables.
- R10: irq_o is high exactly when the status register AND the enable mask is non-zero.
- R11: A line in general-purpose mode never sets its status bit, whatever its trigger configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, takes effect at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | LINES | Asynchronous pin inputs |
| pin_out | output | LINES | Output data to the pads |
| pin_oe | output | LINES | Output enable to the pads |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the first rising edge after the strobe. The input data register reflects a pin change after two edges. Status bits and irq_o react three edges after a pin change: two synchroniser edges, then the status flop. The bench drives inputs on falling edges and counts falling edges before it samples. The edge timing is checked both one cycle early, where the status bit must still be clear, and on time. The acknowledge-versus-edge collision is built by placing the acknowledge write at exactly the edge where the synchronised transition is first seen.

// File: rtl/gpio_bank_pkg.sv
// Shared constants for the GPIO bank: register offsets and bus width.
// Assumes byte addressing with 32-bit registers.
package gpio_bank_pkg;
    localparam int BUS_DW = 32;

    localparam logic [7:0] OFF_MODE  = 8'h00;
    localparam logic [7:0] OFF_DIR   = 8'h04;
    localparam logic [7:0] OFF_DOUT  = 8'h08;
    localparam logic [7:0] OFF_DIN   = 8'h0C;
    localparam logic [7:0] OFF_STAT  = 8'h10;
    localparam logic [7:0] OFF_ACK   = 8'h14;
    localparam logic [7:0] OFF_MASK  = 8'h18;
    localparam logic [7:0] OFF_UNMSK = 8'h1C;
    localparam logic [7:0] OFF_POL   = 8'h20;
    localparam logic [7:0] OFF_TRIG  = 8'h24;
    localparam logic [7:0] OFF_DUAL  = 8'h4C;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Shift the pins through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpio_line_detect.sv
// Per-line interrupt detector: keeps the previous synchronised level and one
// status flop. Level mode tracks the polarity-adjusted pin; edge mode latches
// until acknowledged, and a new edge wins over a same-cycle acknowledge.
// Assumes din is already synchronous to clk.
module gpio_line_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic is_irq,
    input  logic is_edge,
    input  logic act_low,
    input  logic dual,
    input  logic ack,
    output logic stat
);
    logic prev;
    logic rise, fall, hit, lvl;

    // Remember last cycle's level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= din;
    end

    // Select which transition counts and the active level.
    always_comb begin
        rise = din & ~prev;
        fall = ~din & prev;
        if (dual)         hit = rise | fall;
        else if (act_low) hit = fall;
        else              hit = rise;
        lvl = din ^ act_low;
    end

    // Update the status flop according to the line's mode.
    always_ff @(posedge clk) begin
        if (!rst_n)        stat <= 1'b0;
        else if (!is_irq)  stat <= 1'b0;
        else if (!is_edge) stat <= lvl;
        else               stat <= hit | (stat & ~ack);
    end
endmodule

// File: rtl/gpio_regs.sv
// Register file of the GPIO bank: configuration, output data and enable mask,
// plus the read multiplexer and the acknowledge pulse vector.
// Assumes LINES <= 32; unused upper data bits read as zero.
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [LINES-1:0]  din_sync,
    input  logic [LINES-1:0]  stat_vec,
    output logic [LINES-1:0]  mode_q,
    output logic [LINES-1:0]  dir_q,
    output logic [LINES-1:0]  dout_q,
    output logic [LINES-1:0]  mask_q,
    output logic [LINES-1:0]  pol_q,
    output logic [LINES-1:0]  trig_q,
    output logic [LINES-1:0]  dual_q,
    output logic [LINES-1:0]  ack_vec
);
    logic [LINES-1:0] wd;

    assign wd = bus_wdata[LINES-1:0];

    function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    // Store configuration and data registers on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dir_q  <= '0;
            dout_q <= '0;
            pol_q  <= '0;
            trig_q <= '0;
            dual_q <= '0;
        end else if (bus_we) begin
            if (hit_addr(bus_addr, OFF_MODE)) mode_q <= wd;
            if (hit_addr(bus_addr, OFF_DIR))  dir_q  <= wd;
            if (hit_addr(bus_addr, OFF_DOUT)) dout_q <= wd;
            if (hit_addr(bus_addr, OFF_POL))  pol_q  <= wd;
            if (hit_addr(bus_addr, OFF_TRIG)) trig_q <= wd;
            if (hit_addr(bus_addr, OFF_DUAL)) dual_q <= wd;
        end
    end

    // Enable mask: zeros clear at one address, ones set at another.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (bus_we) begin
            if (hit_addr(bus_addr, OFF_MASK))       mask_q <= mask_q & wd;
            else if (hit_addr(bus_addr, OFF_UNMSK)) mask_q <= mask_q | wd;
        end
    end

    // One-cycle acknowledge pulses for the detectors.
    always_comb begin
        ack_vec = (bus_we && hit_addr(bus_addr, OFF_ACK)) ? wd : '0;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if      (hit_addr(bus_addr, OFF_MODE)) bus_rdata = BUS_DW'(mode_q);
        else if (hit_addr(bus_addr, OFF_DIR))  bus_rdata = BUS_DW'(dir_q);
        else if (hit_addr(bus_addr, OFF_DOUT)) bus_rdata = BUS_DW'(dout_q);
        else if (hit_addr(bus_addr, OFF_DIN))  bus_rdata = BUS_DW'(din_sync);
        else if (hit_addr(bus_addr, OFF_STAT)) bus_rdata = BUS_DW'(stat_vec);
        else if (hit_addr(bus_addr, OFF_MASK)) bus_rdata = BUS_DW'(mask_q);
        else if (hit_addr(bus_addr, OFF_POL))  bus_rdata = BUS_DW'(pol_q);
        else if (hit_addr(bus_addr, OFF_TRIG)) bus_rdata = BUS_DW'(trig_q);
        else if (hit_addr(bus_addr, OFF_DUAL)) bus_rdata = BUS_DW'(dual_q);
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// Top of the GPIO bank: synchroniser, one detector per line, register file
// and the combined interrupt. Assumes a single clock and LINES <= 32.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic              irq_o
);
    logic [LINES-1:0] din_sync;
    logic [LINES-1:0] stat_q;
    logic [LINES-1:0] mode_q, dir_q, dout_q, mask_q, pol_q, trig_q, dual_q, ack_vec;

    gpio_sync #(.W(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .d_sync  (din_sync)
    );

    gpio_regs #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .din_sync  (din_sync),
        .stat_vec  (stat_q),
        .mode_q    (mode_q),
        .dir_q     (dir_q),
        .dout_q    (dout_q),
        .mask_q    (mask_q),
        .pol_q     (pol_q),
        .trig_q    (trig_q),
        .dual_q    (dual_q),
        .ack_vec   (ack_vec)
    );

    for (genvar k = 0; k < LINES; k++) begin : g_line
        gpio_line_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (din_sync[k]),
            .is_irq  (mode_q[k]),
            .is_edge (trig_q[k]),
            .act_low (pol_q[k]),
            .dual    (dual_q[k]),
            .ack     (ack_vec[k]),
            .stat    (stat_q[k])
        );
    end

    // Pad drive and combined interrupt.
    always_comb begin
        pin_out = dout_q;
        pin_oe  = dir_q & ~mode_q;
        irq_o   = |(stat_q & mask_q);
    end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Assertion checker for the GPIO bank, bound to the top module.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [LINES-1:0]  mask_q,
    input logic [LINES-1:0]  mode_q,
    input logic [LINES-1:0]  stat_q,
    input logic [LINES-1:0]  pin_oe
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && stat_q == '0));

    assert_no_drive_irq_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & mode_q) == '0);

    assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_MASK))
        |=> mask_q == ($past(mask_q) & $past(bus_wdata[LINES-1:0])));

    assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_UNMSK))
        |=> mask_q == ($past(mask_q) | $past(bus_wdata[LINES-1:0])));

    assert_gpio_no_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stat_q & ~$past(mode_q)) == '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .mask_q    (mask_q),
    .mode_q    (mode_q),
    .stat_q    (stat_q),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_irq_bank_bench.sv
// Scoreboard bench: the driver queues expected values, the monitor compares.
module gpio_irq_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 32;
    localparam int ADDR_W = 8;

    localparam int K_RD = 0, K_IRQ = 1, K_OE = 2, K_OUT = 3;

    typedef struct {
        int          kind;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [LINES-1:0]  pin_in = '0;
    logic [LINES-1:0]  pin_out, pin_oe;
    logic              irq_o;

    item_t sb_q[$];
    event  sb_ev;
    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank #(.LINES(LINES), .ADDR_W(ADDR_W)) u_gpio_irq_bank (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .pin_in, .pin_out, .pin_oe, .irq_o
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input int kind, input logic [7:0] a,
                               input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
        bus_addr = a; bus_we = 1'b0;
        sb_q.push_back(it);
        -> sb_ev;
        #2;
        @(negedge clk);
    endtask

    // Monitor: pop each expected item and compare with the design output.
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            @(sb_ev);
            #1;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = {31'b0, irq_o};
                K_OE:    act = pin_oe;
                default: act = pin_out;
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        // R1 reset state
        expect_item(K_RD, 8'h00, 32'h0, "R1 mode");
        expect_item(K_RD, 8'h08, 32'h0, "R1 dout");
        expect_item(K_RD, 8'h18, 32'h0, "R1 mask");
        expect_item(K_RD, 8'h10, 32'h0, "R1 stat");
        expect_item(K_IRQ, 8'h00, 32'h0, "R1 irq");
        expect_item(K_OE, 8'h00, 32'h0, "R1 oe");
        // R2 output drive
        wr(8'h04, 32'h30);
        wr(8'h08, 32'h10);
        wr(8'h00, 32'h10);
        expect_item(K_OE, 8'h00, 32'h20, "R2 oe");
        expect_item(K_OUT, 8'h00, 32'h10, "R2 pin_out");
        expect_item(K_RD, 8'h08, 32'h10, "R2 dout read");
        // R3 input sync
        pin_in = 32'hA00;
        ticks(2);
        expect_item(K_RD, 8'h0C, 32'hA00, "R3 din");
        // Interrupt configuration
        wr(8'h24, 32'h0D);
        wr(8'h20, 32'h0E);
        wr(8'h4C, 32'h04);
        wr(8'h00, 32'h0F);
        ticks(2);
        expect_item(K_RD, 8'h10, 32'h02, "R6 level active");
        // R9 / R10 mask
        wr(8'h1C, 32'h0F);
        expect_item(K_RD, 8'h18, 32'h0F, "R9 set");
        expect_item(K_IRQ, 8'h00, 32'h1, "R10 irq on");
        wr(8'h18, 32'hFFFF_FFFD);
        expect_item(K_RD, 8'h18, 32'h0D, "R9 clear");
        expect_item(K_IRQ, 8'h00, 32'h0, "R10 irq masked");
        // R6 ack has no effect while level active
        wr(8'h14, 32'h02);
        expect_item(K_RD, 8'h10, 32'h02, "R6 ack ignored");
        pin_in[1] = 1'b1;
        ticks(3);
        expect_item(K_RD, 8'h10, 32'h00, "R6 level inactive");
        // R4 rising edge timing
        pin_in[0] = 1'b1;
        ticks(2);
        expect_item(K_RD, 8'h10, 32'h00, "R4 not early");
        expect_item(K_RD, 8'h10, 32'h01, "R4 rising");
        expect_item(K_IRQ, 8'h00, 32'h1, "R10 irq edge");
        // R7 zero bits no effect, one bit clears
        wr(8'h14, 32'h0E);
        expect_item(K_RD, 8'h10, 32'h01, "R7 zeros keep");
        wr(8'h14, 32'h01);
        expect_item(K_RD, 8'h10, 32'h00, "R7 clear");
        expect_item(K_IRQ, 8'h00, 32'h0, "R10 irq off");
        pin_in[0] = 1'b0;
        ticks(3);
        expect_item(K_RD, 8'h10, 32'h00, "R4 no falling on rising line");
        // R4 falling line
        pin_in[3] = 1'b1;
        ticks(3);
        expect_item(K_RD, 8'h10, 32'h00, "R4 no rising on falling line");
        pin_in[3] = 1'b0;
        ticks(3);
        expect_item(K_RD, 8'h10, 32'h08, "R4 falling");
        wr(8'h14, 32'h08);
        // R5 dual edge
        pin_in[2] = 1'b1;
        ticks(3);
        expect_item(K_RD, 8'h10, 32'h04, "R5 rise");
        wr(8'h14, 32'h04);
        pin_in[2] = 1'b0;
        ticks(3);
        expect_item(K_RD, 8'h10, 32'h04, "R5 fall");
        wr(8'h14, 32'h04);
        // R8 edge beats same-cycle ack
        pin_in[0] = 1'b1;
        ticks(3);
        pin_in[0] = 1'b0;
        ticks(3);
        expect_item(K_RD, 8'h10, 32'h01, "R8 pre");
        pin_in[0] = 1'b1;
        ticks(2);
        wr(8'h14, 32'h01);
        expect_item(K_RD, 8'h10, 32'h01, "R8 kept");
        wr(8'h14, 32'h01);
        expect_item(K_RD, 8'h10, 32'h00, "R8 later clear");
        // R11 general line with edge config
        wr(8'h24, 32'h2D);
        pin_in[5] = 1'b1;
        ticks(3);
        pin_in[5] = 1'b0;
        ticks(3);
        expect_item(K_RD, 8'h10, 32'h00, "R11 no status");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule